// File: doc/BRIEF.md
# Multiprocessor UART Receiver

This block is the receive side of a four-mode serial port. It oversamples the serial line on a tick that runs at sixteen times the bit rate. It assembles either a synchronous 8-bit shift frame or an asynchronous frame with 8 or 9 data bits. It checks the stop bit and posts the received byte with an interrupt flag. A sticky framing-error flag records any frame whose stop bit was sampled low.

For networks with several nodes, a filter can hold back every frame that is not addressed to this node. When the filter is on, a frame is reported only if it is an address frame and its byte matches either the node's own address or the broadcast address. Two inputs define those addresses: a node address and a compare mask. A mask bit of 1 means the bit is compared, and a mask bit of 0 means the bit is ignored. The own address is the node address. The broadcast address is the node address ORed with the mask.

Software controls the block through one 8-bit control register. Bit 7 of that register holds either the high mode bit or the framing-error flag, and a select input chooses which.

Top module: `uart_mp_rx`

## Requirements
- R1: After reset, the control register reads 0x00, and the received byte, the ninth-bit flag, the interrupt flag and the framing-error flag are all 0.
- R2: While the receive-enable bit (control bit 4) is 0, no frame is received. The interrupt flag is not set and the received byte is unchanged.
- R3: In the asynchronous modes, a frame begins on a falling edge of the line. The start bit is kept only if the majority of samples 7, 8 and 9 (of the 16 samples in the bit) is low. Every later bit is decided by the same majority vote.
- R4: Mode 1 (control bits 7:6 = 01) receives 8 data bits, LSB first. On acceptance, the ninth-bit flag (control bit 2) loads the sampled stop bit.
- R5: Modes 2 and 3 (control bits 7:6 = 10 and 11) receive 8 data bits and then a ninth bit. On acceptance, the ninth-bit flag loads that ninth bit.
- R6: The framing-error flag is set whenever a stop bit is sampled low. It stays set through later valid frames and through writes with the select input low. It changes only on a write with the select input high, which loads write-data bit 7.
- R7: With the select input high, bit 7 of the control register reads and writes the framing-error flag. With the select input low, bit 7 reads and writes the high mode bit. Bits 3 and 1 read 0.
- R8: In the asynchronous modes, the interrupt flag (control bit 0) rises at the sample point halfway through the stop bit. In mode 0 it rises at the end of the eighth bit time.
- R9: In modes 2 and 3 with the filter bit (control bit 5) set, a frame is accepted only if its ninth bit is 1 and its byte equals the own address or the broadcast address on every bit where the mask is 1.
- R10: In mode 1 with the filter bit set, a frame is accepted only if its stop bit is 1 and its byte matches the own or broadcast address.
- R11: A frame that completes while the interrupt flag is 1 is discarded. The received byte and the ninth-bit flag keep their values.
- R12: In mode 0, reception starts on the first tick after receive enable is 1 and the interrupt flag is 0. Eight bits are taken LSB first, each lasting 16 ticks.
- R13: The interrupt flag, once set, stays 1 until a control write loads 0 into bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial data line |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| fe_sel_i | input | 1 | Selects framing-error flag (1) or high mode bit (0) at control bit 7 |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read data |
| node_addr_i | input | DATA_W | Node address |
| addr_mask_i | input | DATA_W | Address compare mask, 1 = compare |
| rx_data_o | output | DATA_W | Last accepted byte |
| rb8_o | output | 1 | Ninth-bit flag |
| ri_o | output | 1 | Receive interrupt flag |
| fe_o | output | 1 | Framing-error flag |

## Verification
The hardest case to reach from the ports is a frame that completes at the exact moment the filter decides. This has to be covered for each of the filter's four outcomes: own address, broadcast, mismatch, and data frame (ninth bit 0). The bench reaches these by sending the same byte with the ninth bit flipped, a byte that differs from the own address only in compared bits, and a byte whose compared bits are all 1.

A second hard case is a short low glitch that starts a frame and must then be dropped at mid-bit. The bench pulses the line low for three ticks and follows it with a real frame, which must arrive byte-aligned.

Interrupt timing is checked one tick before and at the stop-bit sample point. Those tick positions are derived from the bench's own tick schedule.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP,
    ST_SHIFT
  } rx_state_e;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_8BIT  = 2'b01,
    MODE_9BIT  = 2'b10,
    MODE_9VAR  = 2'b11
  } rx_mode_e;

  localparam int unsigned CTRL_W      = 8;
  localparam int unsigned BIT_MODE_HI = 7;
  localparam int unsigned BIT_MODE_LO = 6;
  localparam int unsigned BIT_FILT    = 5;
  localparam int unsigned BIT_REN     = 4;
  localparam int unsigned BIT_RB8     = 2;
  localparam int unsigned BIT_RI      = 0;

endpackage

// File: rtl/uart_mp_rx_sync.sv
module uart_mp_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_mp_rx_vote.sv
module uart_mp_rx_vote #(
  parameter int unsigned OVS   = 16,
  parameter int unsigned CNT_W = $clog2(OVS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rxd_i,
  output logic             bit_o,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OVS / 2 + 1);

  logic smp_a_q, smp_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else if (tick_i) begin
      if (cnt_i == SMP_A) smp_a_q <= rxd_i;
      if (cnt_i == SMP_B) smp_b_q <= rxd_i;
    end
  end

  assign valid_o = tick_i && (cnt_i == SMP_C);
  assign bit_o   = (smp_a_q & smp_b_q) | (smp_a_q & rxd_i) | (smp_b_q & rxd_i);

endmodule

// File: rtl/uart_mp_rx_addr.sv
module uart_mp_rx_addr #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] node_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              hit_o
);

  logic [DATA_W-1:0] bcast;
  logic              own_hit, bcast_hit;

  assign bcast     = node_i | mask_i;
  assign own_hit   = ((byte_i ^ node_i) & mask_i) == '0;
  assign bcast_hit = ((byte_i ^ bcast) & mask_i) == '0;
  assign hit_o     = own_hit | bcast_hit;

endmodule

// File: rtl/uart_mp_rx_frame.sv
module uart_mp_rx_frame
  import uart_mp_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16,
  parameter int unsigned CNT_W  = $clog2(OVS),
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  rx_mode_e          mode_i,
  input  logic              en_i,
  input  logic              hold_i,
  input  logic              vote_i,
  input  logic              vote_valid_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              stop_o,
  output logic              frame_done_o,
  output logic              shift_done_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              b9_q;
  logic              armed_q;
  logic              end_tick;

  assign end_tick = tick_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      b9_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && tick_i)
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (rxd_i) armed_q <= 1'b1;
          if (tick_i) begin
            if (mode_i == MODE_SHIFT) begin
              if (!hold_i) begin
                state_q <= ST_SHIFT;
                cnt_q   <= CNT_W'(1);
                idx_q   <= '0;
              end
            end else if (!rxd_i && armed_q) begin
              // detection tick counts as sample 0 of the start bit
              state_q <= ST_START;
              cnt_q   <= CNT_W'(1);
              armed_q <= 1'b0;
            end
          end
        end
        ST_START: begin
          if (vote_valid_i && vote_i) state_q <= ST_IDLE;
          else if (end_tick) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
        end
        ST_DATA, ST_SHIFT: begin
          if (vote_valid_i) sh_q <= {vote_i, sh_q[DATA_W-1:1]};
          if (end_tick) begin
            if (idx_q == IDX_LAST) begin
              if (state_q == ST_SHIFT) state_q <= ST_IDLE;
              else if (mode_i[1])      state_q <= ST_NINTH;
              else                     state_q <= ST_STOP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_NINTH: begin
          if (vote_valid_i) b9_q <= vote_i;
          if (end_tick) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (vote_valid_i) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnt_o        = cnt_q;
  assign data_o       = sh_q;
  assign bit9_o       = b9_q;
  assign stop_o       = vote_i;
  assign frame_done_o = en_i && (state_q == ST_STOP) && vote_valid_i;
  assign shift_done_o = en_i && (state_q == ST_SHIFT) && end_tick && (idx_q == IDX_LAST);

  p_disable_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_IDLE);

  p_false_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_START && vote_valid_i && vote_i) |=> state_q == ST_IDLE);

  p_shift_wait_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_IDLE && mode_i == MODE_SHIFT && hold_i) |=> state_q == ST_IDLE);

endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              fe_sel_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_rdata_o,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic [DATA_W-1:0] addr_mask_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rb8_o,
  output logic              ri_o,
  output logic              fe_o
);

  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              mode_hi_q, mode_lo_q, filt_q, ren_q, rb8_q, ri_q, fe_q;
  logic [DATA_W-1:0] data_q;
  logic              rxd_s, vote_bit, vote_vld;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] fr_data;
  logic              fr_b9, fr_stop, fr_done, sh_done, addr_hit;
  logic              take, fe_set, accept_ok, rb8_nxt;
  rx_mode_e          mode;
  logic              unused_wbits;

  assign mode         = rx_mode_e'({mode_hi_q, mode_lo_q});
  assign unused_wbits = ^{ctrl_wdata_i[3], ctrl_wdata_i[1]};

  uart_mp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_mp_rx_vote #(.OVS(OVS), .CNT_W(CNT_W)) u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick16_i),
    .cnt_i  (cnt),
    .rxd_i  (rxd_s),
    .bit_o  (vote_bit),
    .valid_o(vote_vld)
  );

  uart_mp_rx_frame #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick16_i),
    .rxd_i       (rxd_s),
    .mode_i      (mode),
    .en_i        (ren_q),
    .hold_i      (ri_q),
    .vote_i      (vote_bit),
    .vote_valid_i(vote_vld),
    .cnt_o       (cnt),
    .data_o      (fr_data),
    .bit9_o      (fr_b9),
    .stop_o      (fr_stop),
    .frame_done_o(fr_done),
    .shift_done_o(sh_done)
  );

  uart_mp_rx_addr #(.DATA_W(DATA_W)) u_addr (
    .byte_i(fr_data),
    .node_i(node_addr_i),
    .mask_i(addr_mask_i),
    .hit_o (addr_hit)
  );

  always_comb begin
    accept_ok = 1'b0;
    rb8_nxt   = rb8_q;
    fe_set    = 1'b0;
    take      = 1'b0;
    if (fr_done) begin
      fe_set = !fr_stop;
      if (mode == MODE_8BIT) begin
        accept_ok = !filt_q || (fr_stop && addr_hit);
        rb8_nxt   = fr_stop;
      end else begin
        accept_ok = !filt_q || (fr_b9 && addr_hit);
        rb8_nxt   = fr_b9;
      end
      take = accept_ok && !ri_q;
    end else if (sh_done) begin
      take = !ri_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_hi_q <= 1'b0;
      mode_lo_q <= 1'b0;
      filt_q    <= 1'b0;
      ren_q     <= 1'b0;
      rb8_q     <= 1'b0;
      ri_q      <= 1'b0;
      fe_q      <= 1'b0;
      data_q    <= '0;
    end else begin
      if (ctrl_we_i) begin
        mode_lo_q <= ctrl_wdata_i[BIT_MODE_LO];
        filt_q    <= ctrl_wdata_i[BIT_FILT];
        ren_q     <= ctrl_wdata_i[BIT_REN];
        if (!fe_sel_i) mode_hi_q <= ctrl_wdata_i[BIT_MODE_HI];
      end
      // hardware events win over a same-cycle write
      if (fe_set)                      fe_q <= 1'b1;
      else if (ctrl_we_i && fe_sel_i)  fe_q <= ctrl_wdata_i[BIT_MODE_HI];
      if (take) begin
        ri_q   <= 1'b1;
        data_q <= fr_data;
        if (fr_done) rb8_q <= rb8_nxt;
      end else if (ctrl_we_i) begin
        ri_q  <= ctrl_wdata_i[BIT_RI];
        rb8_q <= ctrl_wdata_i[BIT_RB8];
      end
    end
  end

  assign ctrl_rdata_o = {fe_sel_i ? fe_q : mode_hi_q, mode_lo_q, filt_q, ren_q,
                         1'b0, rb8_q, 1'b0, ri_q};
  assign rx_data_o    = data_q;
  assign rb8_o        = rb8_q;
  assign ri_o         = ri_q;
  assign fe_o         = fe_q;

  p_fe_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_q && !(ctrl_we_i && fe_sel_i)) |=> fe_q);

  p_ri_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_q && !ctrl_we_i) |=> ri_q);

  p_no_overwrite_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_q |=> $stable(data_q));

  p_rx_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ren_q && !ctrl_we_i) |=> !$rose(ri_q));

endmodule

// File: tb/uart_mp_rx_tb.sv
module uart_mp_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       fe_sel = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] node = 8'h34;
  logic [7:0] mask = 8'hF0;
  logic [7:0] rx_data;
  logic       rb8, ri, fe;

  int checks_n = 0;
  int fails_n  = 0;
  int cyc      = 0;
  int tdiv     = 0;
  logic [7:0] exp_data = 8'h00;

  logic       last_we = 1'b0;
  logic       prev_ri = 1'b0;
  logic [7:0] prev_data = 8'h00;

  always #2 clk = ~clk;

  uart_mp_rx u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rxd_i       (rxd),
    .tick16_i    (tick),
    .fe_sel_i    (fe_sel),
    .ctrl_we_i   (we),
    .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(rdata),
    .node_addr_i (node),
    .addr_mask_i (mask),
    .rx_data_o   (rx_data),
    .rb8_o       (rb8),
    .ri_o        (ri),
    .fe_o        (fe)
  );

  always @(negedge clk) begin
    tick = (tdiv == 0);
    tdiv = (tdiv + 1) % 4;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks_n++;
    if (act !== exp) begin
      fails_n++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock model: flag falls only on a write, byte changes only with flag rise
  always @(posedge clk) last_we <= we;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ri && !ri) chk("R13 flag fell without write", {31'd0, last_we}, 32'd1);
      if (rx_data !== prev_data) chk("R11 byte changed without flag rise", {31'd0, (!prev_ri && ri)}, 32'd1);
    end
    prev_ri   <= ri;
    prev_data <= rx_data;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails_n++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
      $finish;
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v, input logic sel);
    wait_ticks(1);
    fe_sel = sel;
    wdata  = v;
    we     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we     = 1'b0;
    fe_sel = 1'b0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [7:0] exp);
    fe_sel = sel;
    #1;
    chk(req, {24'd0, rdata}, {24'd0, exp});
    fe_sel = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic nine, input logic b9,
                      input logic stop, input logic ri_after);
    logic ri_before;
    ri_before = ri;
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      wait_ticks(16);
    end
    if (nine) begin
      rxd = b9;
      wait_ticks(16);
    end
    rxd = stop;
    wait_ticks(9);
    chk("R8 flag before stop sample", {31'd0, ri}, {31'd0, ri_before});
    wait_ticks(1);
    chk("R8 flag at stop sample", {31'd0, ri}, {31'd0, ri_after});
    wait_ticks(6);
    rxd = 1'b1;
    wait_ticks(4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 ctrl reset", 1'b0, 8'h00);
    rd("R1 ctrl reset fe view", 1'b1, 8'h00);
    chk("R1 data reset", {24'd0, rx_data}, 32'h00);
    chk("R1 flags reset", {29'd0, rb8, ri, fe}, 32'd0);

    // R4 mode 1, 8 bits, RB8 = stop
    wr(8'h50, 1'b0);
    wait_ticks(20);
    send(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 byte", {24'd0, rx_data}, 32'hA5);
    chk("R4 rb8 is stop", {31'd0, rb8}, 32'd1);

    // R11 discard while flag set
    send(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R11 byte kept", {24'd0, rx_data}, 32'hA5);
    chk("R13 flag still set", {31'd0, ri}, 32'd1);
    wr(8'h50, 1'b0);
    chk("R13 flag cleared by write", {31'd0, ri}, 32'd0);

    // R3 short glitch dropped, next frame aligned
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(40);
    chk("R3 glitch no frame", {31'd0, ri}, 32'd0);
    send(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R3 frame after glitch", {24'd0, rx_data}, 32'h5A);
    wr(8'h50, 1'b0);

    // R6/R7 framing error
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 fe set", {31'd0, fe}, 32'd1);
    chk("R4 rb8 loads low stop", {31'd0, rb8}, 32'd0);
    rd("R7 bit7 shows fe", 1'b1, 8'hD1);
    rd("R7 bit7 shows mode", 1'b0, 8'h51);
    wr(8'h50, 1'b0);
    chk("R6 fe kept after mode write", {31'd0, fe}, 32'd1);
    send(8'h22, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 fe kept after good frame", {31'd0, fe}, 32'd1);
    chk("R4 byte 22", {24'd0, rx_data}, 32'h22);
    wr(8'h50, 1'b1);
    chk("R6 fe cleared via select", {31'd0, fe}, 32'd0);
    rd("R7 mode bit untouched", 1'b0, 8'h50);

    // R2 receive disabled
    wr(8'h40, 1'b0);
    send(8'h77, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 byte unchanged", {24'd0, rx_data}, 32'h22);

    // R10 mode 1 with filter, own 0x3x, broadcast 0xFx
    wr(8'h70, 1'b0);
    wait_ticks(20);
    send(8'h39, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 own address taken", {24'd0, rx_data}, 32'h39);
    wr(8'h70, 1'b0);
    send(8'h3B, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 bad stop rejected", {24'd0, rx_data}, 32'h39);
    chk("R6 fe on rejected frame", {31'd0, fe}, 32'd1);
    send(8'h52, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 mismatch rejected", {24'd0, rx_data}, 32'h39);
    send(8'hF7, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 broadcast taken", {24'd0, rx_data}, 32'hF7);

    // R5 mode 2 no filter
    wr(8'h90, 1'b0);
    wait_ticks(20);
    send(8'h12, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5 byte", {24'd0, rx_data}, 32'h12);
    chk("R5 rb8 ninth 0", {31'd0, rb8}, 32'd0);

    // R9 mode 3 with filter
    wr(8'hF0, 1'b0);
    send(8'h3A, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9 own address taken", {24'd0, rx_data}, 32'h3A);
    chk("R5 rb8 ninth 1", {31'd0, rb8}, 32'd1);
    wr(8'hF0, 1'b0);
    send(8'h3A, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 data frame rejected", {31'd0, ri}, 32'd0);
    send(8'h45, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R9 mismatch rejected", {24'd0, rx_data}, 32'h3A);
    send(8'hF2, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9 broadcast taken", {24'd0, rx_data}, 32'hF2);

    // R12 mode 0 shift reception
    exp_data = 8'hC6;
    wr(8'h00, 1'b0);
    rxd = exp_data[0];
    wr(8'h10, 1'b0);
    wait_ticks(1);
    for (int k = 0; k < 7; k++) begin
      rxd = exp_data[k];
      wait_ticks(16);
    end
    rxd = exp_data[7];
    wait_ticks(14);
    chk("R8 mode0 flag before end", {31'd0, ri}, 32'd0);
    wait_ticks(2);
    chk("R8 mode0 flag at end", {31'd0, ri}, 32'd1);
    chk("R12 mode0 byte", {24'd0, rx_data}, {24'd0, exp_data});
    wr(8'h00, 1'b0);
    rxd = 1'b1;
    wait_ticks(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
    $finish;
  end

endmodule